// File: doc/BRIEF.md
# SPI Master Serial-Clock and Framing-Delay Timer

This block times everything an SPI master does in the time domain. It works out the serial clock period and the three chip-select framing delays: select-to-first-edge, last-edge-to-deselect, and the idle gap after a frame. It then counts them out in system clocks. A frame engine beside it asks for one timing phase at a time with a one-cycle `go` strobe. That strobe carries a phase code and the index of one of two attribute sets. The timer answers with one-cycle strobes: a leading and a trailing serial-clock edge strobe in the clock phase, and a done strobe for each delay phase. Shifting data, driving chip-select lines and choosing frames belong to the frame engine.

Every length comes from a two-stage product rather than from one integer divider. An odd-or-even prescale factor (2, 3, 5 or 7) is multiplied by a scale factor. For the serial clock the scale factor is 2, 4, 6 or 8 for the first four codes and a power of two above that. For a delay it is always a power of two. An optional double-rate bit halves the serial clock period. A simple register write port programs the attribute sets. Lengths are snapshotted when `go` is taken, so the sets may be rewritten while a phase runs. All control pins are plain level or pulse signals with no back-pressure: `go` is always accepted in the cycle it is high.

Top module: `spi_sck_delay_timer`

## Requirements
- R1: After reset all five output strobes are low and stay low until the first `go`.
- R2: The serial clock period in system clocks is P = prescale × scale. Prescale code 0..3 gives 2, 3, 5, 7. Scale code c gives 2c+2 for c < 4 and 2^c for c ≥ 4. With double rate off the high and low parts are equal.
- R3: With the double-rate bit set, P = prescale × scale / 2. The first part of each period lasts ceil(P/2) clocks and the second lasts floor(P/2).
- R4: `go` with phase CLOCK (code 2) starts the clock phase. `sck_lead` is high in the H-th cycle after the `go` edge, where H is the first part. `sck_trail` is high in the P-th cycle. Both then repeat every P cycles until the next `go`.
- R5: `go` with phase LEAD (1), TRAIL (3) or GAP (4) times a delay of D = prescale × 2^(code+1) system clocks. D uses that delay's own codes, and the double-rate bit has no effect on it. The matching done strobe is high in the D-th cycle after the `go` edge.
- R6: A done strobe lasts exactly one cycle. No strobe follows it until the next `go`.
- R7: Two attribute sets exist. `cfg_we` writes `cfg_data` into the set at `cfg_idx`, and `go_sel` picks the set used by a phase. The fields of `cfg_data` are: [0] double rate, [2:1] clock prescale, [6:3] clock scale, [8:7] lead prescale, [12:9] lead scale, [14:13] trail prescale, [18:15] trail scale, [20:19] gap prescale, [24:21] gap scale.
- R8: A `go` taken while a phase is running restarts counting from zero with the new phase.
- R9: `go` with phase STOP (code 0), or with an unused code 5..7, ends any running phase and no strobe appears afterwards.
- R10: Lengths are captured when `go` is taken. Rewriting the selected set during a phase does not change that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Attribute set write strobe |
| cfg_idx | input | 1 | Attribute set written |
| cfg_data | input | 25 | Attribute set contents (fields in R7) |
| go | input | 1 | One-cycle phase start |
| go_sel | input | 1 | Attribute set used by the started phase |
| go_phase | input | 3 | Phase code: 0 stop, 1 lead, 2 clock, 3 trail, 4 gap |
| sck_lead | output | 1 | Leading serial clock edge strobe |
| sck_trail | output | 1 | Trailing serial clock edge strobe |
| lead_done | output | 1 | Select-to-clock delay elapsed |
| trail_done | output | 1 | Clock-to-deselect delay elapsed |
| gap_done | output | 1 | Inter-frame gap elapsed |

## Verification
A wrong count or a wrong snapshot in the timer moves an edge or done strobe by whole cycles. That error is visible at the strobe's first expected position, within one period or one delay of `go`. A decode error in the product arithmetic shows directly as a wrong measured length for the affected code. That is why the bench measures the smallest product, the largest double-rate clock product and odd prescale factors in double mode. A stuck phase state shows as a missing strobe or as strobes continuing after a done or a stop. The bench watches for these during quiet windows after each phase.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  localparam int PRE_W   = 2;
  localparam int SCL_W   = 4;
  localparam int MAX_PRE = 7;
  localparam int CNT_W   = $clog2(MAX_PRE) + (1 << SCL_W) + 1;

  typedef logic [PRE_W-1:0] pre_code_t;
  typedef logic [SCL_W-1:0] scl_code_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    PH_STOP  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_CLOCK = 3'd2,
    PH_TRAIL = 3'd3,
    PH_GAP   = 3'd4
  } phase_e;

  typedef struct packed {
    scl_code_t gap_s;
    pre_code_t gap_p;
    scl_code_t trail_s;
    pre_code_t trail_p;
    scl_code_t lead_s;
    pre_code_t lead_p;
    scl_code_t baud_s;
    pre_code_t baud_p;
    logic      dbl;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);

  function automatic cnt_t pre_factor(pre_code_t c);
    case (c)
      2'd0:    return cnt_t'(2);
      2'd1:    return cnt_t'(3);
      2'd2:    return cnt_t'(5);
      default: return cnt_t'(7);
    endcase
  endfunction

  function automatic cnt_t baud_scale(scl_code_t c);
    if (c < scl_code_t'(4)) return cnt_t'({c, 1'b0}) + cnt_t'(2);
    return cnt_t'(1) << c;
  endfunction

  function automatic cnt_t delay_len(pre_code_t p, scl_code_t s);
    return pre_factor(p) << (int'(s) + 1);
  endfunction

endpackage

// File: rtl/sdt_attr_file.sv
module sdt_attr_file
  import sdt_pkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter int SEL_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  attr_t            wr_data,
  input  logic [SEL_W-1:0] rd_idx,
  output attr_t            rd_data
);

  attr_t bank [NUM_SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SETS; i++) bank[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_SETS; i++)
        if (wr_idx == SEL_W'(i)) bank[i] <= wr_data;
    end
  end

  assign rd_data = bank[rd_idx];

  generate
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_chk
      AST_SET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == SEL_W'(g)) |=> (bank[g] == $past(wr_data))) // R7
        else $error("attribute set write lost");
      AST_SET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == SEL_W'(g)) |=> $stable(bank[g])) // R10
        else $error("attribute set changed without write");
    end
  endgenerate

endmodule

// File: rtl/sdt_len_calc.sv
module sdt_len_calc
  import sdt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  attr_t  attr,
  input  phase_e phase,
  output cnt_t   len_a,
  output cnt_t   len_p
);

  cnt_t prod;
  cnt_t per;
  cnt_t first_part;
  cnt_t d_lead;
  cnt_t d_trail;
  cnt_t d_gap;

  always_comb begin
    prod       = pre_factor(attr.baud_p) * baud_scale(attr.baud_s);
    per        = attr.dbl ? (prod >> 1) : prod;
    first_part = per - (per >> 1);
    d_lead     = delay_len(attr.lead_p, attr.lead_s);
    d_trail    = delay_len(attr.trail_p, attr.trail_s);
    d_gap      = delay_len(attr.gap_p, attr.gap_s);
  end

  always_comb begin
    case (phase)
      PH_CLOCK: begin len_a = first_part; len_p = per;     end
      PH_LEAD:  begin len_a = d_lead;     len_p = d_lead;  end
      PH_TRAIL: begin len_a = d_trail;    len_p = d_trail; end
      PH_GAP:   begin len_a = d_gap;      len_p = d_gap;   end
      default:  begin len_a = '0;         len_p = '0;      end
    endcase
  end

  AST_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLOCK) |-> (len_p >= cnt_t'(2) && len_a >= cnt_t'(1) && len_a < len_p)) // R3
    else $error("clock period split out of range");
  AST_DELAY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LEAD || phase == PH_TRAIL || phase == PH_GAP) |-> (len_a >= cnt_t'(4))) // R5
    else $error("delay shorter than smallest product");

endmodule

// File: rtl/sdt_phase_timer.sv
module sdt_phase_timer
  import sdt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go,
  input  phase_e go_phase,
  input  cnt_t   new_len_a,
  input  cnt_t   new_len_p,
  output logic   sck_lead,
  output logic   sck_trail,
  output logic   lead_done,
  output logic   trail_done,
  output logic   gap_done
);

  logic   active;
  phase_e kind;
  cnt_t   cnt;
  cnt_t   len_a;
  cnt_t   len_p;
  logic   at_a;
  logic   at_p;
  logic   any_done;

  assign at_a = (cnt == len_a - cnt_t'(1));
  assign at_p = (cnt == len_p - cnt_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      kind   <= PH_STOP;
      cnt    <= '0;
      len_a  <= '0;
      len_p  <= '0;
    end else if (go) begin
      cnt  <= '0;
      kind <= go_phase;
      if (go_phase != PH_STOP) begin
        active <= 1'b1;
        len_a  <= new_len_a;
        len_p  <= new_len_p;
      end else begin
        active <= 1'b0;
      end
    end else if (active) begin
      if (kind == PH_CLOCK) begin
        cnt <= at_p ? '0 : cnt + cnt_t'(1);
      end else if (at_a) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + cnt_t'(1);
      end
    end
  end

  always_comb begin
    sck_lead   = active && kind == PH_CLOCK && at_a;
    sck_trail  = active && kind == PH_CLOCK && at_p;
    lead_done  = active && kind == PH_LEAD  && at_a;
    trail_done = active && kind == PH_TRAIL && at_a;
    gap_done   = active && kind == PH_GAP   && at_a;
    any_done   = lead_done || trail_done || gap_done;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sck_lead, sck_trail, lead_done, trail_done, gap_done})) // R6
    else $error("two strobes at once");
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < len_p)) // R4
    else $error("counter past its length");
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (any_done && !go) |=> !(sck_lead || sck_trail || lead_done || trail_done || gap_done)) // R6
    else $error("strobe after done");
  AST_LEAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_lead && !go) |=> !sck_lead) // R4
    else $error("leading edge strobe repeated");
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (go && go_phase == PH_STOP) |=> !(sck_lead || sck_trail || lead_done || trail_done || gap_done)) // R9
    else $error("strobe after stop");
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (go && go_phase != PH_STOP) |=> (active && cnt == '0)) // R8
    else $error("start did not clear counter");

endmodule

// File: rtl/spi_sck_delay_timer.sv
module spi_sck_delay_timer
  import sdt_pkg::*;
#(
  parameter int NUM_SETS = 2,
  localparam int SEL_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_idx,
  input  logic [ATTR_W-1:0] cfg_data,
  input  logic              go,
  input  logic [SEL_W-1:0]  go_sel,
  input  logic [2:0]        go_phase,
  output logic              sck_lead,
  output logic              sck_trail,
  output logic              lead_done,
  output logic              trail_done,
  output logic              gap_done
);

  attr_t  sel_attr;
  phase_e ph;
  cnt_t   calc_a;
  cnt_t   calc_p;

  always_comb begin
    case (go_phase)
      3'd1:    ph = PH_LEAD;
      3'd2:    ph = PH_CLOCK;
      3'd3:    ph = PH_TRAIL;
      3'd4:    ph = PH_GAP;
      default: ph = PH_STOP;
    endcase
  end

  sdt_attr_file #(.NUM_SETS(NUM_SETS), .SEL_W(SEL_W)) u_attr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (attr_t'(cfg_data)),
    .rd_idx  (go_sel),
    .rd_data (sel_attr)
  );

  sdt_len_calc u_calc (
    .clk   (clk),
    .rst_n (rst_n),
    .attr  (sel_attr),
    .phase (ph),
    .len_a (calc_a),
    .len_p (calc_p)
  );

  sdt_phase_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .go_phase   (ph),
    .new_len_a  (calc_a),
    .new_len_p  (calc_p),
    .sck_lead   (sck_lead),
    .sck_trail  (sck_trail),
    .lead_done  (lead_done),
    .trail_done (trail_done),
    .gap_done   (gap_done)
  );

endmodule

// File: tb/spi_sck_delay_timer_bench.sv
module spi_sck_delay_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_idx = '0;
  logic [24:0] cfg_data = '0;
  logic        go = 1'b0;
  logic [0:0]  go_sel = '0;
  logic [2:0]  go_phase = '0;
  logic        sck_lead, sck_trail, lead_done, trail_done, gap_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  spi_sck_delay_timer u_spi_sck_delay_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .go(go), .go_sel(go_sel), .go_phase(go_phase),
    .sck_lead(sck_lead), .sck_trail(sck_trail),
    .lead_done(lead_done), .trail_done(trail_done), .gap_done(gap_done)
  );

  // Expected values from the requirement text (R2, R5).
  function automatic int pre_of(int c);
    case (c) 0: return 2; 1: return 3; 2: return 5; default: return 7; endcase
  endfunction
  function automatic int scl_of(int c);
    return (c < 4) ? 2 * c + 2 : (1 << c);
  endfunction
  function automatic int dly_of(int p, int s);
    return pre_of(p) * (1 << (s + 1));
  endfunction

  // Field layout from R7.
  function automatic logic [24:0] mk(int dbl, int bp, int bs, int lp, int ls,
                                     int tp, int ts, int gp, int gs);
    return {4'(gs), 2'(gp), 4'(ts), 2'(tp), 4'(ls), 2'(lp), 4'(bs), 2'(bp), 1'(dbl)};
  endfunction

  function automatic logic evt(int which);
    case (which)
      0: return sck_lead;
      1: return sck_trail;
      2: return lead_done;
      3: return trail_done;
      default: return gap_done;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_set(input int idx, input logic [24:0] d);
    cfg_idx = 1'(idx); cfg_data = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_go(input int sel, input int ph);
    go_sel = 1'(sel); go_phase = 3'(ph); go = 1'b1;
  endtask

  // Counts negedges until the chosen strobe is seen; n=1 is the first cycle after the go edge.
  task automatic wait_evt(input int which, input int cap, output int n);
    n = 0;
    do begin
      @(negedge clk);
      go = 1'b0;
      n++;
    end while (!evt(which) && n < cap);
  endtask

  task automatic quiet(input int cycles, input string tag);
    int hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      go = 1'b0;
      if (sck_lead || sck_trail || lead_done || trail_done || gap_done) hits++;
    end
    chk(hits == 0, tag, hits, 0);
  endtask

  task automatic t_reset();
    chk({sck_lead, sck_trail, lead_done, trail_done, gap_done} == 5'b0, "R1 outputs after reset",
        {sck_lead, sck_trail, lead_done, trail_done, gap_done}, 0);
    quiet(10, "R1 quiet before first go");
  endtask

  task automatic t_clock(input int sel, input int dbl, input int bp, input int bs, input string tag);
    int p, h, l, n;
    p = pre_of(bp) * scl_of(bs);
    if (dbl != 0) p = p / 2;
    h = p - p / 2;
    l = p / 2;
    pulse_go(sel, 2);
    wait_evt(0, p + 4, n);
    chk(n == h, {tag, " first leading edge"}, n, h);
    wait_evt(1, p + 4, n);
    chk(n == l, {tag, " leading to trailing"}, n, l);
    wait_evt(0, p + 4, n);
    chk(n == h, {tag, " trailing to next leading"}, n, h);
    pulse_go(sel, 0);
    quiet(2 * p + 4 > 200 ? 200 : 2 * p + 4, "R9 no edges after stop");
  endtask

  task automatic t_delay(input int sel, input int ph, input int exp, input string tag);
    int n;
    pulse_go(sel, ph);
    wait_evt(ph == 1 ? 2 : (ph == 3 ? 3 : 4), exp + 8, n);
    chk(n == exp, tag, n, exp);
    quiet(20, "R6 single done pulse then idle");
  endtask

  task automatic t_restart();
    int n;
    write_set(0, mk(0, 0, 0, 2, 3, 0, 0, 0, 0)); // lead = 5*16 = 80
    pulse_go(0, 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      go = 1'b0;
    end
    pulse_go(0, 1);
    wait_evt(2, 120, n);
    chk(n == 80, "R8 restart counts from second go", n, 80);
    quiet(5, "R8 idle after restarted delay");
  endtask

  task automatic t_stop();
    write_set(0, mk(0, 0, 0, 0, 0, 0, 0, 2, 3)); // gap = 80
    pulse_go(0, 4);
    for (int i = 0; i < 5; i++) begin @(negedge clk); go = 1'b0; end
    pulse_go(0, 0);
    quiet(100, "R9 stop cancels running gap");
    pulse_go(0, 4);
    for (int i = 0; i < 5; i++) begin @(negedge clk); go = 1'b0; end
    pulse_go(0, 6);
    quiet(100, "R9 unused phase code halts");
  endtask

  task automatic t_snapshot();
    int n;
    write_set(1, mk(0, 0, 0, 1, 2, 0, 0, 0, 0)); // lead = 3*8 = 24
    pulse_go(1, 1);
    @(negedge clk);
    go = 1'b0;
    write_set(1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0)); // lead = 4
    wait_evt(2, 40, n);
    n = n + 2;
    chk(n == 24, "R10 rewrite during phase ignored", n, 24);
    pulse_go(1, 1);
    wait_evt(2, 40, n);
    chk(n == 4, "R10 next go uses new set", n, 4);
    quiet(5, "R10 idle after delay");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R2 smallest product 2*2 and other codes
    write_set(0, mk(0, 0, 0, 0, 0, 3, 10, 2, 3));
    t_clock(0, 0, 0, 0, "R2 R4 min 2x2");
    write_set(0, mk(0, 2, 4, 0, 0, 0, 0, 0, 0));
    t_clock(0, 0, 2, 4, "R2 prescale 5 scale 16");
    write_set(0, mk(0, 1, 3, 0, 0, 0, 0, 0, 0));
    t_clock(0, 0, 1, 3, "R2 prescale 3 scale 8");
    // R3 double rate
    write_set(1, mk(1, 0, 0, 0, 0, 0, 0, 0, 0));
    t_clock(1, 1, 0, 0, "R3 double 2x2");
    write_set(1, mk(1, 1, 0, 0, 0, 0, 0, 0, 0));
    t_clock(1, 1, 1, 0, "R3 double odd 3x2");
    write_set(1, mk(1, 3, 15, 0, 0, 0, 0, 0, 0));
    t_clock(1, 1, 3, 15, "R3 double max 7x32768");
    // R5 delays with own codes, double bit set to show it has no effect
    write_set(0, mk(1, 3, 15, 0, 0, 3, 10, 2, 3));
    t_delay(0, 1, dly_of(0, 0), "R5 lead min");
    t_delay(0, 3, dly_of(3, 10), "R5 trail 7x2048");
    t_delay(0, 4, dly_of(2, 3), "R5 gap 5x16");
    // R7 set selection
    write_set(1, mk(0, 0, 0, 1, 2, 0, 0, 0, 0));
    t_delay(1, 1, dly_of(1, 2), "R7 set 1 lead");
    t_delay(0, 1, dly_of(0, 0), "R7 set 0 unchanged");
    t_restart();
    t_stop();
    t_snapshot();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule